// File: doc/BRIEF.md
# Phase truncation spur analyzer

This block examines a frequency tuning word meant for a phase accumulator whose output is cut down to fewer phase bits. After a start pulse it captures the tuning word, the accumulator width and the kept phase width. It then finds how many trailing zero bits the tuning word has by shifting it one bit per clock. From that single count it derives every figure that describes the phase truncation error:

- the spur class of the word;
- how long the whole accumulator sequence runs before it repeats;
- the folded (alias corrected) value of the dropped low field, and how long that field takes to repeat;
- how many sawtooth harmonics an analysis of the spurs has to cover;
- the bound on spur level below the carrier.

The results sit in registers. They are announced by a one cycle `done` pulse and stay put until the next accepted start. A frequency planner uses the block to score candidate tuning words before it commits one to the synthesizer. No spectrum or spur amplitude is computed.

Top module: `trunc_spur_analyzer`

## Requirements
- R1: After reset, `busy`, `done` and `invalid` are 0, `spur_class` is 0, `full_period` and `trunc_period` are 1, and `etw`, `harmonics` and `bound_q88` are 0.
- R2: Let B = A - P and let z be the number of trailing zeros of the tuning word masked to A bits. `spur_class` is 0 (no truncation spurs) when z >= B, 2 (worst case) when z = B - 1, and 1 (intermediate) otherwise.
- R3: `full_period` equals 2^(A - z), which is 2^A divided by GCD(T, 2^A).
- R4: `etw` is the low B bits of T. When bit B-1 of that field is 1, `etw` is 2^B minus the field instead.
- R5: `trunc_period` equals 2^B / GCD(etw, 2^B). It is 1 when the low B bits are all zero.
- R6: `harmonics` equals 2^(B-1) / GCD(etw, 2^B) when the low field is nonzero, and 0 when it is zero.
- R7: `bound_q88` equals P * 1541. This is the magnitude below carrier of about 6.02*P dB, as unsigned Q8.8.
- R8: A request is invalid when the masked tuning word is zero, when P = 0, when P >= A, or when A > AW_MAX. It then reports `invalid`=1, class 0, both periods 1, and `etw`, `harmonics` and `bound_q88` all 0.
- R9: `done` rises no more than A+4 clock edges after the edge that accepts `start`. It is high for exactly one cycle, and the results hold their values until the next accepted start.
- R10: A `start` while `busy` is 1 has no effect on the results. Tuning word bits at position A and above have no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, accepted when not busy |
| tword | input | AW_MAX | Tuning word |
| acc_bits | input | WW | Accumulator width A |
| phase_bits | input | WW | Kept phase width P |
| busy | output | 1 | Analysis in progress |
| done | output | 1 | One cycle pulse when results are updated |
| invalid | output | 1 | Last request was invalid |
| spur_class | output | 2 | 0 none, 1 intermediate, 2 worst |
| full_period | output | AW_MAX+1 | Accumulator repetition period in clocks |
| etw | output | AW_MAX | Alias corrected truncation field |
| trunc_period | output | AW_MAX+1 | Truncation field repetition period |
| harmonics | output | AW_MAX+1 | Sawtooth harmonic count |
| bound_q88 | output | 16 | Worst spur bound, dB below carrier, Q8.8 |

## Verification
The bench aims at the class boundaries: a dropped field of exactly a single top bit, an all-zero dropped field, and a one-bit dropped field with an odd word. A design that mixed up the zero-count comparison would swap worst with intermediate, or none with worst. It also uses a dropped field whose top bit is set, so a missing alias fold shows up as a wrong `etw`. It uses words that are zero only after masking to A bits, and widths with P >= A, which a design without full validity checks would score as real results. A start issued while a run is in progress is there to catch designs that re-latch their inputs mid-scan, and a full width accumulator (A = AW_MAX) exposes shift overflow in `full_period`.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_MID   = 2'd1,
    CLS_WORST = 2'd2
  } spur_class_e;

  localparam int BOUND_W = 16;
  // 6.02 dB per phase bit in Q8.8 (6.02 * 256 = 1541.1)
  localparam logic [BOUND_W-1:0] DB_PER_BIT_Q88 = 16'd1541;
endpackage

// File: rtl/tsa_tz_scan.sv
module tsa_tz_scan #(
  parameter int AW_MAX = 32,
  parameter int WW     = $clog2(AW_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [AW_MAX-1:0] word,
  input  logic [WW-1:0]     limit,
  output logic [WW-1:0]     zeros,
  output logic              finished
);
  logic [AW_MAX-1:0] sh_q;
  logic [WW-1:0]     cnt_q, lim_q;
  logic              run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      lim_q    <= '0;
      run_q    <= 1'b0;
      finished <= 1'b0;
    end else begin
      finished <= 1'b0;
      if (load) begin
        sh_q  <= word;
        cnt_q <= '0;
        lim_q <= limit;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!sh_q[0] && cnt_q < lim_q) begin
          sh_q  <= sh_q >> 1;
          cnt_q <= cnt_q + WW'(1);
        end else begin
          run_q    <= 1'b0;
          finished <= 1'b1;
        end
      end
    end
  end

  assign zeros = cnt_q;

  // R9
  scan_within_limit_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> cnt_q <= lim_q);
endmodule

// File: rtl/tsa_derive.sv
module tsa_derive
  import tsa_pkg::*;
#(
  parameter int AW_MAX = 32,
  parameter int WW     = $clog2(AW_MAX + 1),
  parameter int PW     = AW_MAX + 1
) (
  input  logic [AW_MAX-1:0]  word,
  input  logic [WW-1:0]      a_bits,
  input  logic [WW-1:0]      p_bits,
  input  logic [WW-1:0]      tz,
  input  logic               bad,
  output spur_class_e        cls,
  output logic [PW-1:0]      full_per,
  output logic [AW_MAX-1:0]  etw_o,
  output logic [PW-1:0]      trunc_per,
  output logic [PW-1:0]      harm,
  output logic [BOUND_W-1:0] bound
);
  logic [WW-1:0] b, k;
  logic [PW-1:0] fmask, low, folded;

  always_comb begin
    b      = a_bits - p_bits;
    k      = (tz < b) ? tz : b;
    fmask  = (PW'(1) << b) - PW'(1);
    low    = {1'b0, word} & fmask;
    folded = ((low & (PW'(1) << (b - WW'(1)))) != '0) ? (PW'(1) << b) - low : low;
    if (bad) begin
      cls       = CLS_NONE;
      full_per  = PW'(1);
      etw_o     = '0;
      trunc_per = PW'(1);
      harm      = '0;
      bound     = '0;
    end else begin
      if (tz >= b)                cls = CLS_NONE;
      else if (tz == b - WW'(1))  cls = CLS_WORST;
      else                        cls = CLS_MID;
      full_per  = PW'(1) << (a_bits - tz);
      etw_o     = folded[AW_MAX-1:0];
      trunc_per = PW'(1) << (b - k);
      harm      = (k < b) ? (PW'(1) << (b - k - WW'(1))) : '0;
      bound     = BOUND_W'(p_bits) * DB_PER_BIT_Q88;
    end
  end
endmodule

// File: rtl/trunc_spur_analyzer.sv
module trunc_spur_analyzer
  import tsa_pkg::*;
#(
  parameter int AW_MAX = 32,
  parameter int WW     = $clog2(AW_MAX + 1),
  parameter int PW     = AW_MAX + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [AW_MAX-1:0]  tword,
  input  logic [WW-1:0]      acc_bits,
  input  logic [WW-1:0]      phase_bits,
  output logic               busy,
  output logic               done,
  output logic               invalid,
  output logic [1:0]         spur_class,
  output logic [PW-1:0]      full_period,
  output logic [AW_MAX-1:0]  etw,
  output logic [PW-1:0]      trunc_period,
  output logic [PW-1:0]      harmonics,
  output logic [BOUND_W-1:0] bound_q88
);
  localparam int LW = 8;

  logic [AW_MAX-1:0] mask, word_q;
  logic [WW-1:0]     a_q, p_q, tz;
  logic              take, scan_fin, bad;
  spur_class_e       d_cls;
  logic [PW-1:0]     d_full, d_trunc, d_harm;
  logic [AW_MAX-1:0] d_etw;
  logic [BOUND_W-1:0] d_bound;

  always_comb begin
    for (int i = 0; i < AW_MAX; i++) mask[i] = (i < int'(acc_bits));
  end

  assign take = start && !busy;
  assign bad  = (word_q == '0) || (p_q == '0) || (p_q >= a_q) ||
                (int'(a_q) > AW_MAX);

  tsa_tz_scan #(.AW_MAX(AW_MAX), .WW(WW)) u_scan (
    .clk(clk), .rst(rst), .load(take), .word(tword & mask),
    .limit(acc_bits), .zeros(tz), .finished(scan_fin)
  );

  tsa_derive #(.AW_MAX(AW_MAX), .WW(WW), .PW(PW)) u_derive (
    .word(word_q), .a_bits(a_q), .p_bits(p_q), .tz(tz), .bad(bad),
    .cls(d_cls), .full_per(d_full), .etw_o(d_etw), .trunc_per(d_trunc),
    .harm(d_harm), .bound(d_bound)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      done         <= 1'b0;
      invalid      <= 1'b0;
      spur_class   <= CLS_NONE;
      full_period  <= PW'(1);
      etw          <= '0;
      trunc_period <= PW'(1);
      harmonics    <= '0;
      bound_q88    <= '0;
      word_q       <= '0;
      a_q          <= '0;
      p_q          <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        busy   <= 1'b1;
        word_q <= tword & mask;
        a_q    <= acc_bits;
        p_q    <= phase_bits;
      end else if (busy && scan_fin) begin
        busy         <= 1'b0;
        done         <= 1'b1;
        invalid      <= bad;
        spur_class   <= d_cls;
        full_period  <= d_full;
        etw          <= d_etw;
        trunc_period <= d_trunc;
        harmonics    <= d_harm;
        bound_q88    <= d_bound;
      end
    end
  end

  // latency window counter for the checks below
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst || !busy) lat_q <= '0;
    else if (lat_q != '1) lat_q <= lat_q + LW'(1);
  end

  // R9
  latency_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> int'(lat_q) <= int'(a_q) + 4);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  hold_results_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(full_period) && $stable(spur_class) && $stable(etw));
  // R2
  worst_shape_chk: assert property (@(posedge clk) disable iff (rst)
    done && spur_class == CLS_WORST |-> trunc_period == PW'(2) && harmonics == PW'(1));
  // R6
  none_shape_chk: assert property (@(posedge clk) disable iff (rst)
    done && spur_class == CLS_NONE |-> trunc_period == PW'(1) && harmonics == '0 && etw == '0);
  // R8
  invalid_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    done && invalid |-> full_period == PW'(1) && bound_q88 == '0);
endmodule

// File: tb/trunc_spur_analyzer_tb.sv
module trunc_spur_analyzer_tb;
  localparam int AW = 32;
  localparam int WW = 6;
  localparam int PW = 33;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] tword = '0;
  logic [WW-1:0] acc_bits = '0, phase_bits = '0;
  logic busy, done, invalid;
  logic [1:0] spur_class;
  logic [PW-1:0] full_period, trunc_period, harmonics;
  logic [AW-1:0] etw;
  logic [15:0] bound_q88;
  int errors = 0, checks = 0;

  always #4ns clk = ~clk;

  trunc_spur_analyzer #(.AW_MAX(AW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .tword(tword), .acc_bits(acc_bits),
    .phase_bits(phase_bits), .busy(busy), .done(done), .invalid(invalid),
    .spur_class(spur_class), .full_period(full_period), .etw(etw),
    .trunc_period(trunc_period), .harmonics(harmonics), .bound_q88(bound_q88)
  );

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic model(input longint unsigned t_in, input int a, input int p,
                       output longint unsigned cls, output longint unsigned fp,
                       output longint unsigned e, output longint unsigned tp,
                       output longint unsigned hm, output longint unsigned bd,
                       output longint unsigned inv);
    longint unsigned t, cap;
    int b, z, g;
    t = t_in & ((64'd1 << a) - 1);
    b = a - p;
    inv = (t == 0 || p == 0 || p >= a || a > AW) ? 1 : 0;
    if (inv != 0) begin
      cls = 0; fp = 1; e = 0; tp = 1; hm = 0; bd = 0;
      return;
    end
    z = 0;
    while (((t >> z) & 1) == 0) z++;
    fp  = 64'd1 << (a - z);
    cap = 64'd1 << b;
    e   = t % cap;
    if (e >= (cap >> 1)) e = cap - e;
    g   = (z < b) ? z : b;
    tp  = cap >> g;
    hm  = (g < b) ? ((cap >> 1) >> g) : 0;
    cls = (z >= b) ? 0 : (z == b - 1) ? 2 : 1;
    bd  = longint'(p) * 1541;
  endtask

  task automatic run(input logic [AW-1:0] t, input int a, input int p, input bit poke);
    longint unsigned cls, fp, e, tp, hm, bd, inv;
    int n;
    model(longint'(t), a, p, cls, fp, e, tp, hm, bd, inv);
    @(negedge clk);
    tword = t; acc_bits = WW'(a); phase_bits = WW'(p); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (poke) begin
      tword = ~t; phase_bits = WW'(1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 2;
    end
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R9", "done within A+4", (done && n <= a + 4) ? 1 : 0, 1);
    chk("R2", "spur_class", spur_class, cls);
    chk("R3", "full_period", full_period, fp);
    chk("R4", "etw", etw, e);
    chk("R5", "trunc_period", trunc_period, tp);
    chk("R6", "harmonics", harmonics, hm);
    chk("R7", "bound_q88", bound_q88, bd);
    chk("R8", "invalid", invalid, inv);
    if (poke) chk("R10", "start while busy ignored", full_period, fp);
    @(negedge clk);
    chk("R9", "done one cycle", done, 0);
    chk("R9", "results held", full_period, fp);
  endtask

  initial begin
    #(8ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "invalid", invalid, 0);
    chk("R1", "class", spur_class, 0);
    chk("R1", "full_period", full_period, 1);
    chk("R1", "trunc_period", trunc_period, 1);
    chk("R1", "etw/harm/bound", etw + harmonics + bound_q88, 0);

    run(32'd182898, 20, 8, 0);          // R4 alias fold, intermediate
    run(32'h0000_0800, 24, 12, 0);      // R2 worst
    run(32'h0000_1000, 24, 12, 0);      // R2 none, R6 zero harmonics
    run(32'h0000_0001, 32, 31, 0);      // R2 B=1 odd word, R3 full width
    run(32'h8000_0000, 32, 4, 0);       // R3 largest zero run
    run(32'd0, 16, 8, 0);               // R8 zero word
    run(32'h0000_0123, 12, 12, 0);      // R8 P >= A
    run(32'h0000_0123, 12, 0, 0);       // R8 P = 0
    run(32'hFFFF_0000, 16, 8, 0);       // R10 upper bits ignored -> invalid
    run(32'hFFF0_0010, 16, 8, 0);       // R10 upper bits ignored
    run(32'h0000_0A5A, 20, 6, 1);       // R10 start while busy
    run(32'h0000_0003, 8, 2, 1);        // R10 poke on shortest run

    for (int i = 0; i < 150; i++) begin
      int a, p, b;
      logic [AW-1:0] t;
      a = 2 + int'($urandom % 31);
      p = 1 + int'($urandom % (a - 1));
      b = a - p;
      t = $urandom;
      case ($urandom % 4)
        0: t = (t << b) | (AW'(1) << (b - 1));   // worst pattern
        1: t = t << b;                           // none pattern
        default: ;
      endcase
      run(t, a, p, i % 7 == 0);
    end
    report();
  end
endmodule